// File: doc/BRIEF.md
# Hash Input Status Tracker

This block keeps the status word for the data-input side of a block-oriented message hashing engine. It watches writes into the data-input register, the start-of-message and final-calculation commands, the DMA enable and activity signals, the free space in the input FIFO, and the events that the hashing core raises as it starts and finishes digest work. It turns all of these into one packed 32-bit status word.

Two 5-bit counters follow the message. One counts the words pushed so far. The other counts the words still needed before the next block can be compressed. The first block needs one extra word: the engine holds back a word so that it can tell whether the message continues. For that reason the expected-word counter starts at block size plus one. After each partial digest it rearms to the block size. When the expected count runs out, the block raises a one-cycle request to start a partial computation and subtracts a full block from the pushed count.

Software clears the two interrupt flags by writing zero to them. A combined interrupt line ORs together each flag gated by its enable. A separate qualifier tells the context-save logic whether saved-context registers may show their contents. All pins are plain control and status levels or pulses. No stream interface and no back-pressure exist.

Top module: `hash_in_status`

## Requirements
- R1: After reset the status word equals 0x0011_0001: the data-input flag is 1, the expected count is 17, and every other field is 0.
- R2: Status bit 0 (data-input flag) is set in the cycle after `fifo_free` first reaches at least 16, which means a rise of the condition. It is cleared by a `din_wr` or by a status write with bit 0 equal to 0. A status write with bit 0 equal to 1 leaves it unchanged. When a set and a clear occur together, the set wins.
- R3: Status bit 1 (digest-complete flag) is set by `digest_done`. It is cleared by `init_cmd` or by a status write with bit 1 equal to 0. A status write with bit 1 equal to 1 leaves it unchanged. The set wins over a clear in the same cycle.
- R4: Status bit 2 (DMA flag) becomes 1 after any cycle in which `dma_en` is 1. Once set, it stays 1 while `dma_active` is 1, even if `dma_en` is 0.
- R5: Status bit 3 (busy) is set by `core_start` and cleared by `partial_done` or `digest_done`. A start wins over a clear in the same cycle.
- R6: Status bits 13:9 (pushed count) behave as follows:
  - `init_cmd` sets them to 0.
  - Each `din_wr` adds 1, saturating at 31.
  - On a write that raises the partial-start request, the result is the old count plus 1 minus 16, floored at 0.
- R7: Status bits 20:16 (expected count) behave as follows:
  - `init_cmd` loads 17.
  - Otherwise `partial_done` loads 16, or 15 if `din_wr` occurs in the same cycle.
  - Otherwise each `din_wr` subtracts 1, holding at 0.
  - `init_cmd` takes priority over every other update.
- R8: `partial_start` is a one-cycle pulse. It appears in the cycle after a `din_wr` that finds an expected count of 1, provided neither `init_cmd` nor `partial_done` occurs in that cycle.
- R9: Status bit 15 (data-input-not-empty) is set by `din_wr` and cleared by `init_cmd` or `final_cmd`. A clear wins over a write in the same cycle.
- R10: `ctx_readable` equals the data-input flag at all times, so it is low whenever status bit 0 is 0.
- R11: `irq` equals (bit 0 AND `ie_din`) OR (bit 1 AND `ie_dig`).
- R12: All status bits outside 0–3, 13:9, 15 and 20:16 always read 0. Status writes affect only bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_wr | input | 1 | Pulse: a word was written to the data-input register |
| init_cmd | input | 1 | Pulse: start a new message |
| final_cmd | input | 1 | Pulse: final calculation requested |
| dma_en | input | 1 | DMA enable level |
| dma_active | input | 1 | A DMA transfer is in progress |
| fifo_free | input | 6 | Number of free word locations in the input FIFO |
| core_start | input | 1 | Pulse: the hashing core begins digest work |
| partial_done | input | 1 | Pulse: a partial digest has finished |
| digest_done | input | 1 | Pulse: the whole-message digest is ready |
| sts_wr | input | 1 | Software write to the status word |
| sts_wdata | input | 32 | Data of that write; only bits 0 and 1 are used |
| ie_din | input | 1 | Interrupt enable for the data-input flag |
| ie_dig | input | 1 | Interrupt enable for the digest-complete flag |
| status | output | 32 | Packed status word |
| partial_start | output | 1 | One-cycle request to compress a block |
| irq | output | 1 | Combined interrupt |
| ctx_readable | output | 1 | Saved-context registers may show their contents |

## Verification
Every status field and `partial_start` is a register. An input applied before a rising edge therefore shows on the outputs just after that edge, one cycle later. `irq` and `ctx_readable` are combinational from those registers and the enables, so they are due in the same cycle as the status word. The bench drives all inputs on the falling edge and compares every output a short delay after the next rising edge. Its arithmetic model advances exactly one cycle per step, so each expected value matches that single-register latency.

// File: rtl/hsts_pkg.sv
package hsts_pkg;
  localparam int STS_W     = 32;
  localparam int CNT_W     = 5;
  localparam int POS_DIN   = 0;
  localparam int POS_DIG   = 1;
  localparam int POS_DMA   = 2;
  localparam int POS_BUSY  = 3;
  localparam int POS_PUSH  = 9;
  localparam int POS_NE    = 15;
  localparam int POS_EXP   = 16;

  typedef struct packed {
    logic             din_flag;
    logic             dig_flag;
    logic             dma_flag;
    logic             busy;
    logic [CNT_W-1:0] pushed;
    logic             not_empty;
    logic [CNT_W-1:0] expected;
  } sts_fields_t;

  function automatic logic [STS_W-1:0] pack_status(input sts_fields_t f);
    logic [STS_W-1:0] w;
    w = '0;
    w[POS_DIN]                = f.din_flag;
    w[POS_DIG]                = f.dig_flag;
    w[POS_DMA]                = f.dma_flag;
    w[POS_BUSY]               = f.busy;
    w[POS_PUSH +: CNT_W]      = f.pushed;
    w[POS_NE]                 = f.not_empty;
    w[POS_EXP +: CNT_W]       = f.expected;
    return w;
  endfunction
endpackage

// File: rtl/hsts_irq_flag.sv
module hsts_irq_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= RST_VAL;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R2 / R3: a set in the same cycle as a clear must win
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R3: a clear without a set empties the flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/hsts_word_counters.sv
module hsts_word_counters #(
  parameter int BLOCK_WORDS = 16,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             init_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] pushed_o,
  output logic [CNT_W-1:0] expected_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] EXP_INIT = CNT_W'(BLOCK_WORDS + 1);
  localparam logic [CNT_W-1:0] EXP_BLK  = CNT_W'(BLOCK_WORDS);
  localparam logic [CNT_W-1:0] EXP_BLK1 = CNT_W'(BLOCK_WORDS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   BLK_WIDE = (CNT_W+1)'(BLOCK_WORDS);

  logic [CNT_W-1:0] pushed_q, expected_q, pushed_n, expected_n;
  logic [CNT_W:0]   pushed_inc;
  logic             start_c, start_q;

  assign pushed_inc = {1'b0, pushed_q} + 1'b1;
  assign start_c    = wr_i && (expected_q == CNT_W'(1)) && !init_i && !reload_i;

  always_comb begin
    if (init_i)                           expected_n = EXP_INIT;
    else if (reload_i)                    expected_n = wr_i ? EXP_BLK1 : EXP_BLK;
    else if (wr_i && expected_q != '0)    expected_n = expected_q - 1'b1;
    else                                  expected_n = expected_q;
  end

  always_comb begin
    if (init_i)                 pushed_n = '0;
    else if (!wr_i)             pushed_n = pushed_q;
    else if (start_c)           pushed_n = (pushed_inc >= BLK_WIDE) ?
                                           CNT_W'(pushed_inc - BLK_WIDE) : '0;
    else if (pushed_q == CNT_MAX) pushed_n = CNT_MAX;
    else                        pushed_n = pushed_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pushed_q   <= '0;
      expected_q <= EXP_INIT;
      start_q    <= 1'b0;
    end else begin
      pushed_q   <= pushed_n;
      expected_q <= expected_n;
      start_q    <= start_c;
    end
  end

  assign pushed_o   = pushed_q;
  assign expected_o = expected_q;
  assign start_o    = start_q;

  // R7: a new message always restarts both counters
  p_init_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (expected_o == EXP_INIT && pushed_o == '0));
  // R7: the expected count never exceeds its initial load
  p_exp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expected_o <= EXP_INIT);
  // R8: the start request never lasts two cycles
  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R8: the request comes with the expected count exhausted
  p_start_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> expected_o == '0);
endmodule

// File: rtl/hsts_ctrl_bits.sv
module hsts_ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en_i,
  input  logic dma_active_i,
  input  logic core_start_i,
  input  logic core_end_i,
  input  logic wr_i,
  input  logic empty_i,
  output logic dma_o,
  output logic busy_o,
  output logic not_empty_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_o       <= 1'b0;
      busy_o      <= 1'b0;
      not_empty_o <= 1'b0;
    end else begin
      dma_o <= dma_en_i | (dma_o & dma_active_i);
      if (core_start_i)    busy_o <= 1'b1;
      else if (core_end_i) busy_o <= 1'b0;
      if (empty_i)         not_empty_o <= 1'b0;
      else if (wr_i)       not_empty_o <= 1'b1;
    end
  end

  // R4: enabling DMA always raises the flag
  p_dma_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en_i |=> dma_o);
  // R4: an active transfer holds the flag up
  p_dma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_o && dma_active_i) |=> dma_o);
  // R5: a core start always shows as busy
  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_start_i |=> busy_o);
  // R9: INIT or DCAL empties the input register flag
  p_ne_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty_i |=> !not_empty_o);
endmodule

// File: rtl/hash_in_status.sv
module hash_in_status
  import hsts_pkg::*;
#(
  parameter int BLOCK_WORDS = 16,
  parameter int FREE_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_wr,
  input  logic              init_cmd,
  input  logic              final_cmd,
  input  logic              dma_en,
  input  logic              dma_active,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              core_start,
  input  logic              partial_done,
  input  logic              digest_done,
  input  logic              sts_wr,
  input  logic [STS_W-1:0]  sts_wdata,
  input  logic              ie_din,
  input  logic              ie_dig,
  output logic [STS_W-1:0]  status,
  output logic              partial_start,
  output logic              irq,
  output logic              ctx_readable
);
  sts_fields_t f;
  logic room, room_q, din_set, din_clr, dig_clr;
  logic unused_wdata;

  assign unused_wdata = &{1'b0, sts_wdata[STS_W-1:2]};
  assign room    = fifo_free >= FREE_W'(BLOCK_WORDS);
  assign din_set = room && !room_q;
  assign din_clr = din_wr | (sts_wr & ~sts_wdata[POS_DIN]);
  assign dig_clr = init_cmd | (sts_wr & ~sts_wdata[POS_DIG]);

  always_ff @(posedge clk) begin
    if (!rst_n) room_q <= 1'b1;
    else        room_q <= room;
  end

  hsts_irq_flag #(.RST_VAL(1'b1)) u_din_flag (
    .clk(clk), .rst_n(rst_n), .set_i(din_set), .clr_i(din_clr), .flag_o(f.din_flag));

  hsts_irq_flag #(.RST_VAL(1'b0)) u_dig_flag (
    .clk(clk), .rst_n(rst_n), .set_i(digest_done), .clr_i(dig_clr), .flag_o(f.dig_flag));

  hsts_ctrl_bits u_ctrl (
    .clk(clk), .rst_n(rst_n), .dma_en_i(dma_en), .dma_active_i(dma_active),
    .core_start_i(core_start), .core_end_i(partial_done | digest_done),
    .wr_i(din_wr), .empty_i(init_cmd | final_cmd),
    .dma_o(f.dma_flag), .busy_o(f.busy), .not_empty_o(f.not_empty));

  hsts_word_counters #(.BLOCK_WORDS(BLOCK_WORDS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_i(din_wr), .init_i(init_cmd),
    .reload_i(partial_done), .pushed_o(f.pushed), .expected_o(f.expected),
    .start_o(partial_start));

  assign status       = pack_status(f);
  assign irq          = (f.din_flag & ie_din) | (f.dig_flag & ie_dig);
  assign ctx_readable = f.din_flag;

  // R10: context contents hidden whenever the data-input flag is low
  p_ctx_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !status[POS_DIN] |-> !ctx_readable);
  // R12: reserved bits stay zero
  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 32'hFFE0_41F0) == '0);
  // R2: a data-input write with no new room clears the flag
  p_din_wr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (din_wr && !din_set) |=> !status[POS_DIN]);
  // R11: no interrupt when both enables are low
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_din && !ie_dig) |-> !irq);
endmodule

// File: tb/test_hash_in_status.sv
`timescale 1ns/100ps
module test_hash_in_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_wr = 0, init_cmd = 0, final_cmd = 0, dma_en = 0, dma_active = 0;
  logic [5:0] fifo_free = '0;
  logic core_start = 0, partial_done = 0, digest_done = 0, sts_wr = 0;
  logic [31:0] sts_wdata = '0;
  logic ie_din = 0, ie_dig = 0;
  logic [31:0] status;
  logic partial_start, irq, ctx_readable;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the requirements
  logic m_din = 1, m_dig = 0, m_dma = 0, m_busy = 0, m_ne = 0, m_ps = 0, m_room_q = 1;
  int   m_push = 0, m_exp = 17;

  always #2.5 clk = ~clk;

  hash_in_status i_hash_in_status (
    .clk(clk), .rst_n(rst_n), .din_wr(din_wr), .init_cmd(init_cmd),
    .final_cmd(final_cmd), .dma_en(dma_en), .dma_active(dma_active),
    .fifo_free(fifo_free), .core_start(core_start), .partial_done(partial_done),
    .digest_done(digest_done), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ie_din(ie_din), .ie_dig(ie_dig), .status(status),
    .partial_start(partial_start), .irq(irq), .ctx_readable(ctx_readable));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit room, ps;
    int inc;
    room = fifo_free >= 16;
    if (room && !m_room_q) m_din = 1;
    else if (din_wr || (sts_wr && !sts_wdata[0])) m_din = 0;
    m_room_q = room;
    if (digest_done) m_dig = 1;
    else if (init_cmd || (sts_wr && !sts_wdata[1])) m_dig = 0;
    m_dma = dma_en | (m_dma & dma_active);
    if (core_start) m_busy = 1;
    else if (partial_done || digest_done) m_busy = 0;
    if (init_cmd || final_cmd) m_ne = 0;
    else if (din_wr) m_ne = 1;
    ps = din_wr && m_exp == 1 && !init_cmd && !partial_done;
    inc = m_push + 1;
    if (init_cmd) m_push = 0;
    else if (din_wr) begin
      if (ps) m_push = (inc >= 16) ? inc - 16 : 0;
      else m_push = (inc > 31) ? 31 : inc;
    end
    if (init_cmd) m_exp = 17;
    else if (partial_done) m_exp = din_wr ? 15 : 16;
    else if (din_wr && m_exp != 0) m_exp = m_exp - 1;
    m_ps = ps;
  endtask

  task automatic compare_all();
    chk("R2 data-input flag", 32'(status[0]), 32'(m_din));
    chk("R3 digest flag", 32'(status[1]), 32'(m_dig));
    chk("R4 dma flag", 32'(status[2]), 32'(m_dma));
    chk("R5 busy", 32'(status[3]), 32'(m_busy));
    chk("R6 pushed count", 32'(status[13:9]), 32'(m_push));
    chk("R9 not-empty", 32'(status[15]), 32'(m_ne));
    chk("R7 expected count", 32'(status[20:16]), 32'(m_exp));
    chk("R12 reserved bits", status & 32'hFFE0_41F0, 32'h0);
    chk("R8 partial start", 32'(partial_start), 32'(m_ps));
    chk("R10 context qualifier", 32'(ctx_readable), 32'(m_din));
    chk("R11 irq", 32'(irq), 32'((m_din & ie_din) | (m_dig & ie_dig)));
  endtask

  // inputs set at the falling edge, outputs sampled 1 ns after the rising edge
  task automatic step(input logic [13:0] v);
    @(negedge clk);
    din_wr = v[0]; sts_wr = v[1]; sts_wdata = {30'h3FFF_FFFF, v[3], v[2]};
    fifo_free = v[4] ? 6'd16 : 6'd15; digest_done = v[5]; init_cmd = v[6];
    final_cmd = v[7]; dma_en = v[8]; dma_active = v[9]; core_start = v[10];
    partial_done = v[11]; ie_din = v[12]; ie_dig = v[13];
    model_step();
    @(posedge clk); #1;
    compare_all();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset word
    chk("R1 reset status", status, 32'h0011_0001);
    chk("R10 reset context qualifier", 32'(ctx_readable), 32'h1);
    chk("R8 reset partial start", 32'(partial_start), 32'h0);

    // R2: writing 1 keeps the flag, writing 0 clears it
    step(14'h000E);   // sts_wr with bits 1:0 = 11
    chk("R2 write-one keeps flag", 32'(status[0]), 32'h1);
    step(14'h0002);   // sts_wr with bits 1:0 = 00
    chk("R2 write-zero clears flag", 32'(status[0]), 32'h0);
    // R3: digest set then write-one keep, set beats simultaneous init
    step(14'h0060);   // digest_done + init together
    chk("R3 set beats clear", 32'(status[1]), 32'h1);

    // R6 / R7 / R8: message of 50 words with the core reloading after each start
    step(14'h0040);   // INIT
    for (int w = 0; w < 50; w++) begin
      step(14'h3001);
      if (partial_start) begin
        step(14'h0400);      // core_start
        step(14'h0800);      // partial_done
      end
    end
    step(14'h0080);   // DCAL clears not-empty (R9)
    chk("R9 final clears not-empty", 32'(status[15]), 32'h0);

    // near-exhaustive sweep over all control combinations
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      v = 14'(i) ^ {i[3:0], 10'h0};
      // keep INIT rare so counters reach their limits
      if (v[6] && (i[9:7] != 3'b000)) v[6] = 1'b0;
      step(v);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule